// File: doc/BRIEF.md
# Parallel FPGA Configuration Host Controller

This block sits on the host side of a byte-wide passive configuration link. It loads a stored bitstream into a single FPGA or into a cascaded chain of them. A controlling agent pulses `start` and supplies the image length and a few timing settings. The controller then resets the targets by pulling the active-low start line, waits for the shared status line to come back high, and streams the image out of an external memory one byte per configuration clock. When the shared done line rises it sends a number of extra clocks for target initialization, then reports success.

A chain of targets is treated as one unbroken byte stream. The targets hand over between themselves without help from the host, so the controller never pauses between devices. The status line is open-drain and shared. If any target pulls it low, or done fails to arrive within a timeout after the last byte, the controller restarts the whole chain from byte zero. It does this up to a programmable number of times and then gives up with a sticky failure flag.

The configuration clock is derived from the system clock by a divider. The divider is clamped so that the clock never exceeds the ceiling the targets accept. The memory port is a plain address output with a data input that must follow the address within the same cycle.

Top module: `cfg_chain_loader`

## Requirements
- R1: After synchronous reset `cfgStartN` is 1, `cfgClk` is 0, and `busy`, `loadOk` and `loadFail` are 0.
- R2: A `start` pulse seen while idle drives `cfgStartN` low for exactly max(2, `pulseLen`) system cycles, then releases it. A `start` seen while busy has no effect and produces no second low pulse.
- R3: After each release of `cfgStartN`, no rising edge of `cfgClk` occurs until `cfgStatus` has been seen low and then high.
- R4: Bytes are presented on `cfgData` in address order, starting at memory address 0. Each byte is set up while `cfgClk` is low. The high and low phases of `cfgClk` each last HALF_EFF system cycles, so consecutive data rising edges are 2×HALF_EFF cycles apart. HALF_EFF = max(`HALF_DIV`, ceil(`SYS_HZ` / (2×`MAX_CFG_HZ`))).
- R5: Each attempt sends exactly `imageLen` bytes. `memAddr` increments after every data rising edge and rests at `imageLen` after a successful load.
- R6: A low `cfgStatus` while loading, waiting for done, or sending initialization clocks aborts the attempt. It is followed by a fresh start-line pulse and a reload beginning at address 0.
- R7: If `cfgDone` is not seen high within `doneTimeout` cycles after the last byte, the attempt is treated as the R6 error.
- R8: After `cfgDone` is seen high, exactly `initClocks` further rising edges of `cfgClk` are issued. Then `loadOk` goes to 1, `cfgClk` rests low and `busy` falls.
- R9: At most `retryLimit` automatic restarts follow the first attempt. If the last permitted attempt also fails, `loadFail` goes to 1 and the controller returns to idle.
- R10: `loadOk` and `loadFail` are never both 1. Each holds its value while idle and is cleared by the next accepted `start`.
- R11: `busy` is 1 from the cycle after an accepted `start` until the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a configuration run |
| imageLen | input | ADDR_W | Number of bytes in the image, captured at start |
| pulseLen | input | PULSE_W | Start-line low time in cycles (minimum 2), captured at start |
| initClocks | input | INIT_W | Extra clocks after done, captured at start |
| retryLimit | input | RETRY_W | Maximum automatic restarts, captured at start |
| doneTimeout | input | TOUT_W | Cycles to wait for done after the last byte, captured at start |
| memAddr | output | ADDR_W | Image memory read address |
| memData | input | 8 | Image memory read data for `memAddr`, same cycle |
| cfgStartN | output | 1 | Active-low configuration start line to all targets |
| cfgStatus | input | 1 | Shared open-drain status line, low means reset or error |
| cfgDone | input | 1 | Shared open-drain done line |
| cfgClk | output | 1 | Configuration clock to all targets |
| cfgData | output | 8 | Byte-wide configuration data bus |
| busy | output | 1 | A run is in progress |
| loadOk | output | 1 | Sticky success flag |
| loadFail | output | 1 | Sticky failure flag after retries are used up |

## Verification
The assertions assume that the status line falls while the start line is held low and rises only after it is released. They assume done is low during every fresh attempt, and that the memory data follows the address in the same cycle. The bench's target model enforces this. It pulls status low for every start-line pulse, raises it a few cycles after release, and raises done only after a full image. Faults are injected only by holding status low until the next start-line pulse. Random runs draw lengths, pulse widths, init counts and fault positions within the configured port widths, with memory contents drawn from a fixed seed.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WSTAT,
    ST_LOAD,
    ST_WDONE,
    ST_INIT
  } ldState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;
    logic cntClr;
    logic cntInc;
    logic halfRun;
    logic rise;
    logic fall;
    logic loadByte;
    logic addrClr;
    logic addrInc;
    logic cfgLow;
    logic retryClr;
    logic retryInc;
    logic setOk;
    logic setFail;
    logic clrFlags;
  } ldStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic pulseDone;
    logic timeoutHit;
    logic initDone;
    logic lastByte;
    logic halfDone;
    logic ckHigh;
    logic statusHi;
    logic statusRose;
    logic doneHi;
    logic retryLeft;
  } ldFlags_t;

endpackage

// File: rtl/cfgload_sync.sv
module cfgload_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgload_dp.sv
module cfgload_dp
  import cfgload_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PULSE_W     = 8,
  parameter int INIT_W      = 8,
  parameter int TOUT_W      = 16,
  parameter int RETRY_W     = 4,
  parameter int HALF_EFF    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  ldStrobe_t          stb,
  input  logic [ADDR_W-1:0]  imageLen,
  input  logic [PULSE_W-1:0] pulseLen,
  input  logic [INIT_W-1:0]  initClocks,
  input  logic [RETRY_W-1:0] retryLimit,
  input  logic [TOUT_W-1:0]  doneTimeout,
  input  logic [7:0]         memData,
  input  logic               cfgStatus,
  input  logic               cfgDone,
  output ldFlags_t           flg,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               cfgStartN,
  output logic               cfgClk,
  output logic [7:0]         cfgData,
  output logic               loadOk,
  output logic               loadFail
);
  localparam int CNT_A  = (TOUT_W > PULSE_W) ? TOUT_W : PULSE_W;
  localparam int CNT_W  = (CNT_A > INIT_W) ? CNT_A : INIT_W;
  localparam int HALF_W = $clog2(HALF_EFF + 1);

  logic [ADDR_W-1:0]  lenQ, addrQ;
  logic [PULSE_W-1:0] pulseQ;
  logic [INIT_W-1:0]  initQ;
  logic [TOUT_W-1:0]  toutQ;
  logic [RETRY_W-1:0] retryLimQ, retryQ;
  logic [CNT_W-1:0]   cntQ;
  logic [HALF_W-1:0]  halfQ;
  logic               ckQ, startNQ, okQ, failQ, stPrev;
  logic [7:0]         dataQ;
  logic               stS, dnS;

  cfgload_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stSync (
    .clk(clk), .rst(rst), .d(cfgStatus), .q(stS));
  cfgload_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dnSync (
    .clk(clk), .rst(rst), .d(cfgDone), .q(dnS));

  // settings captured once per run
  always_ff @(posedge clk) begin
    if (rst) begin
      lenQ      <= '0;
      pulseQ    <= PULSE_W'(2);
      initQ     <= '0;
      toutQ     <= '0;
      retryLimQ <= '0;
    end else if (stb.latchCfg) begin
      lenQ      <= imageLen;
      pulseQ    <= (pulseLen < PULSE_W'(2)) ? PULSE_W'(2) : pulseLen;
      initQ     <= initClocks;
      toutQ     <= doneTimeout;
      retryLimQ <= retryLimit;
    end
  end

  // address, general counter, half-period timer
  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      cntQ  <= '0;
      halfQ <= '0;
    end else begin
      if (stb.addrClr)      addrQ <= '0;
      else if (stb.addrInc) addrQ <= addrQ + ADDR_W'(1);

      if (stb.cntClr)                        cntQ <= '0;
      else if (stb.cntInc && (cntQ != '1))   cntQ <= cntQ + CNT_W'(1);

      if (!stb.halfRun || (halfQ == HALF_W'(HALF_EFF - 1))) halfQ <= '0;
      else                                                  halfQ <= halfQ + HALF_W'(1);
    end
  end

  // link outputs, retries and result flags
  always_ff @(posedge clk) begin
    if (rst) begin
      ckQ     <= 1'b0;
      dataQ   <= '0;
      startNQ <= 1'b1;
      retryQ  <= '0;
      okQ     <= 1'b0;
      failQ   <= 1'b0;
      stPrev  <= 1'b0;
    end else begin
      if (stb.rise)      ckQ <= 1'b1;
      else if (stb.fall) ckQ <= 1'b0;
      if (stb.loadByte) dataQ <= memData;
      startNQ <= !stb.cfgLow;
      if (stb.retryClr)      retryQ <= '0;
      else if (stb.retryInc) retryQ <= retryQ + RETRY_W'(1);
      if (stb.clrFlags)   okQ <= 1'b0;
      else if (stb.setOk) okQ <= 1'b1;
      if (stb.clrFlags)     failQ <= 1'b0;
      else if (stb.setFail) failQ <= 1'b1;
      stPrev <= stS;
    end
  end

  always_comb begin
    flg.pulseDone  = cntQ >= (CNT_W'(pulseQ) - CNT_W'(1));
    flg.timeoutHit = cntQ >= CNT_W'(toutQ);
    flg.initDone   = cntQ >= CNT_W'(initQ);
    flg.lastByte   = (addrQ == lenQ);
    flg.halfDone   = (halfQ == HALF_W'(HALF_EFF - 1));
    flg.ckHigh     = ckQ;
    flg.statusHi   = stS;
    flg.statusRose = stS && !stPrev;
    flg.doneHi     = dnS;
    flg.retryLeft  = (retryQ < retryLimQ);
  end

  assign memAddr   = addrQ;
  assign cfgStartN = startNQ;
  assign cfgClk    = ckQ;
  assign cfgData   = dataQ;
  assign loadOk    = okQ;
  assign loadFail  = failQ;

  // R3: the clock only rises while status is seen high
  a_r3_rise_needs_status: assert property (@(posedge clk) disable iff (rst)
    $rose(ckQ) |-> $past(stS));
  // R4: data does not move on the rising edge
  a_r4_data_steady_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(ckQ) |-> $stable(dataQ));
  // R2: the start line is low for at least two cycles
  a_r2_pulse_min: assert property (@(posedge clk) disable iff (rst)
    $rose(startNQ) |-> !$past(startNQ, 2));
  // R8: success only follows a seen done
  a_r8_ok_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(okQ) |-> $past(dnS));
  // R9: restarts never exceed the captured limit
  a_r9_retry_bound: assert property (@(posedge clk) disable iff (rst)
    retryQ <= retryLimQ);
  // R10: result flags are exclusive
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(okQ && failQ));
endmodule

// File: rtl/cfgload_ctrl.sv
module cfgload_ctrl
  import cfgload_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  ldFlags_t  flg,
  output ldStrobe_t stb,
  output logic      busy
);
  ldState_t st, nxt;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  always_comb begin
    stb = '0;
    nxt = st;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          stb.latchCfg = 1'b1;
          stb.clrFlags = 1'b1;
          stb.retryClr = 1'b1;
          stb.addrClr  = 1'b1;
          nxt          = ST_PULSE;
        end
      end
      ST_PULSE: begin
        stb.cfgLow = 1'b1;
        stb.cntInc = 1'b1;
        if (flg.pulseDone) nxt = ST_WSTAT;
      end
      ST_WSTAT: begin
        if (flg.statusRose) begin
          if (flg.lastByte) begin
            nxt = ST_WDONE;
          end else begin
            stb.loadByte = 1'b1;
            nxt          = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        stb.halfRun = 1'b1;
        if (!flg.statusHi) begin
          nxt = ST_IDLE;
        end else if (flg.halfDone) begin
          if (!flg.ckHigh) begin
            stb.rise    = 1'b1;
            stb.addrInc = 1'b1;
          end else begin
            stb.fall = 1'b1;
            if (flg.lastByte) nxt = ST_WDONE;
            else              stb.loadByte = 1'b1;
          end
        end
      end
      ST_WDONE: begin
        stb.cntInc = 1'b1;
        if (!flg.statusHi)      nxt = ST_IDLE;
        else if (flg.doneHi)    nxt = ST_INIT;
        else if (flg.timeoutHit) nxt = ST_IDLE;
      end
      ST_INIT: begin
        stb.halfRun = 1'b1;
        if (!flg.statusHi) begin
          nxt = ST_IDLE;
        end else if (!flg.ckHigh && flg.initDone) begin
          stb.setOk = 1'b1;
          nxt       = ST_IDLE;
        end else if (flg.halfDone) begin
          if (flg.ckHigh) begin
            stb.fall = 1'b1;
          end else begin
            stb.rise   = 1'b1;
            stb.cntInc = 1'b1;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase

    // a fault or timeout leaves a busy state towards idle without success
    if ((st != ST_IDLE) && (nxt == ST_IDLE) && !stb.setOk) begin
      stb.fall    = 1'b1;
      stb.halfRun = 1'b0;
      stb.loadByte = 1'b0;
      if (flg.retryLeft) begin
        stb.retryInc = 1'b1;
        stb.addrClr  = 1'b1;
        nxt          = ST_PULSE;
      end else begin
        stb.setFail = 1'b1;
      end
    end

    stb.cntClr = (nxt != st) || stb.retryInc;
  end

  assign busy = (st != ST_IDLE);

  // R6: a status fault while loading leads to restart or to idle
  a_r6_fault_restarts: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD && !flg.statusHi) |=> (st == ST_PULSE || st == ST_IDLE));
  // R11: leaving idle needs a start request
  a_r11_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R7: waiting for done ends in init only when done is seen
  a_r7_init_needs_done: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WDONE && nxt == ST_INIT) |-> flg.doneHi);
endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader
  import cfgload_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PULSE_W     = 8,
  parameter int INIT_W      = 8,
  parameter int TOUT_W      = 16,
  parameter int RETRY_W     = 4,
  parameter int SYS_HZ      = 250_000_000,
  parameter int MAX_CFG_HZ  = 125_000_000,
  parameter int HALF_DIV    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  imageLen,
  input  logic [PULSE_W-1:0] pulseLen,
  input  logic [INIT_W-1:0]  initClocks,
  input  logic [RETRY_W-1:0] retryLimit,
  input  logic [TOUT_W-1:0]  doneTimeout,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [7:0]         memData,
  output logic               cfgStartN,
  input  logic               cfgStatus,
  input  logic               cfgDone,
  output logic               cfgClk,
  output logic [7:0]         cfgData,
  output logic               busy,
  output logic               loadOk,
  output logic               loadFail
);
  localparam longint CEIL_NUM = longint'(SYS_HZ) + 2 * longint'(MAX_CFG_HZ) - 1;
  localparam int MIN_HALF_RAW = int'(CEIL_NUM / (2 * longint'(MAX_CFG_HZ)));
  localparam int MIN_HALF     = (MIN_HALF_RAW < 1) ? 1 : MIN_HALF_RAW;
  localparam int HALF_EFF     = (HALF_DIV > MIN_HALF) ? HALF_DIV : MIN_HALF;

  ldStrobe_t stb;
  ldFlags_t  flg;

  cfgload_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .flg(flg), .stb(stb), .busy(busy));

  cfgload_dp #(
    .ADDR_W(ADDR_W), .PULSE_W(PULSE_W), .INIT_W(INIT_W), .TOUT_W(TOUT_W),
    .RETRY_W(RETRY_W), .HALF_EFF(HALF_EFF), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .imageLen(imageLen), .pulseLen(pulseLen), .initClocks(initClocks),
    .retryLimit(retryLimit), .doneTimeout(doneTimeout),
    .memData(memData), .cfgStatus(cfgStatus), .cfgDone(cfgDone),
    .flg(flg), .memAddr(memAddr), .cfgStartN(cfgStartN), .cfgClk(cfgClk),
    .cfgData(cfgData), .loadOk(loadOk), .loadFail(loadFail));
endmodule

// File: tb/tb_cfg_chain_loader.sv
module tb_cfg_chain_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [15:0] imageLen;
  logic [7:0]  pulseLen;
  logic [7:0]  initClocks;
  logic [3:0]  retryLimit;
  logic [15:0] doneTimeout;
  logic [15:0] memAddr;
  logic [7:0]  memData;
  logic        cfgStartN, cfgClk, busy, loadOk, loadFail;
  logic        tgtStatus, tgtDone;
  logic [7:0]  cfgData;
  logic [7:0]  mem [0:511];

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign memData = mem[memAddr[8:0]];

  cfg_chain_loader #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst(rst), .start(start), .imageLen(imageLen),
    .pulseLen(pulseLen), .initClocks(initClocks), .retryLimit(retryLimit),
    .doneTimeout(doneTimeout), .memAddr(memAddr), .memData(memData),
    .cfgStartN(cfgStartN), .cfgStatus(tgtStatus), .cfgDone(tgtDone),
    .cfgClk(cfgClk), .cfgData(cfgData), .busy(busy), .loadOk(loadOk),
    .loadFail(loadFail));

  int nChecks = 0, nFail = 0, cyc = 0;
  int lowRun, lastLowWidth, attempts, recv, mism, preRise, initRises;
  int highRun, highMin, highMax, lastRiseT, perMin, perMax;
  int faultsLeft, faultByte, statTimer, doneTimer, modelLen;
  bit riseValid, faultHold, noDone, prevCk, prevN;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // target chain model, evaluated between active edges
  always @(negedge clk) begin
    cyc++;
    if (!cfgStartN) lowRun++;
    else if (lowRun > 0) begin lastLowWidth = lowRun; lowRun = 0; end
    if (!cfgStartN && prevN) attempts++;
    prevN = cfgStartN;
    if (cfgClk) highRun++;
    else if (highRun > 0) begin
      if (highRun < highMin) highMin = highRun;
      if (highRun > highMax) highMax = highRun;
      highRun = 0;
    end
    if (!cfgStartN) begin
      tgtStatus = 1'b0; tgtDone = 1'b0; recv = 0; faultHold = 1'b0;
      statTimer = 0; doneTimer = 0; riseValid = 1'b0;
    end else begin
      if (!tgtStatus && !faultHold) begin
        statTimer++;
        if (statTimer >= 3) tgtStatus = 1'b1;
      end
      if (cfgClk && !prevCk) begin
        if (!tgtStatus) begin
          if (!faultHold) preRise++;
        end else if (tgtDone) begin
          initRises++;
        end else if (recv < modelLen) begin
          if (riseValid) begin
            if (cyc - lastRiseT < perMin) perMin = cyc - lastRiseT;
            if (cyc - lastRiseT > perMax) perMax = cyc - lastRiseT;
          end
          lastRiseT = cyc; riseValid = 1'b1;
          if (cfgData != mem[recv]) mism++;
          recv++;
          if (faultsLeft > 0 && recv == faultByte) begin
            tgtStatus = 1'b0; faultHold = 1'b1; faultsLeft--; riseValid = 1'b0;
          end
        end
      end
      if (tgtStatus && recv == modelLen && !tgtDone && !noDone) begin
        doneTimer++;
        if (doneTimer >= 2) tgtDone = 1'b1;
      end
    end
    prevCk = cfgClk;
  end

  function automatic int expAttempts(int rty, int nf, bit nd);
    if (nd || nf > rty) return rty + 1;
    return nf + 1;
  endfunction

  function automatic int expPulse(int pl);
    return (pl < 2) ? 2 : pl;
  endfunction

  task automatic runLoad(input int len, input int pl, input int ini, input int rty,
                         input int tout, input int nf, input int fb, input bit nd,
                         input bit extraStart);
    int n;
    bit expOk;
    for (int i = 0; i < len; i++) mem[i] = 8'($urandom);
    modelLen = len; faultsLeft = nf; faultByte = fb; noDone = nd;
    attempts = 0; mism = 0; preRise = 0; initRises = 0;
    highMin = 1000; highMax = 0; perMin = 1000; perMax = 0;
    imageLen = 16'(len); pulseLen = 8'(pl); initClocks = 8'(ini);
    retryLimit = 4'(rty); doneTimeout = 16'(tout);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R10", "ok cleared by start", int'(loadOk), 0);
    chk("R10", "fail cleared by start", int'(loadFail), 0);
    chk("R11", "busy after start", int'(busy), 1);
    if (extraStart) begin
      repeat (12) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (busy && n < 40000) begin @(negedge clk); n++; end
    chk("R11", "busy falls at end", int'(busy), 0);
    expOk = !nd && (nf <= rty);
    chk("R8", "success flag", int'(loadOk), int'(expOk));
    chk("R9", "failure flag", int'(loadFail), int'(!expOk));
    chk(nd ? "R7" : "R6", "attempt count", attempts, expAttempts(rty, nf, nd));
    chk("R2", "start line low width", lastLowWidth, expPulse(pl));
    chk("R2", "start line released", int'(cfgStartN), 1);
    chk("R3", "clock rises before status", preRise, 0);
    chk("R8", "clock parked low", int'(cfgClk), 0);
    if (expOk) begin
      chk("R4", "byte mismatches", mism, 0);
      chk("R5", "bytes received", recv, len);
      chk("R5", "final address", int'(memAddr), len);
      chk("R8", "init clock edges", initRises, ini);
      if (nf == 0 && highMax > 0) begin
        chk("R4", "high phase min", highMin, HALF);
        chk("R4", "high phase max", highMax, HALF);
      end
      if (nf == 0 && len >= 2) begin
        chk("R4", "byte period min", perMin, 2 * HALF);
        chk("R4", "byte period max", perMax, 2 * HALF);
      end
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(negedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements): actual %0d cycles expected < %0d", WD_LIMIT, WD_LIMIT);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    tgtStatus = 1'b1; tgtDone = 1'b0; prevCk = 1'b0; prevN = 1'b1;
    lowRun = 0; lastLowWidth = 0; recv = 0; highRun = 0; modelLen = 0;
    faultsLeft = 0; faultByte = 0; noDone = 1'b0; faultHold = 1'b0;
    statTimer = 0; doneTimer = 0; riseValid = 1'b0; lastRiseT = 0;
    start = 1'b0; imageLen = '0; pulseLen = '0; initClocks = '0;
    retryLimit = '0; doneTimeout = '0;
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "start line after reset", int'(cfgStartN), 1);
    chk("R1", "clock after reset", int'(cfgClk), 0);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "flags after reset", int'(loadOk) + int'(loadFail), 0);

    runLoad(5, 3, 4, 2, 100, 0, 0, 1'b0, 1'b0);    // R4 R5 R8 clean load
    runLoad(3, 0, 2, 1, 100, 0, 0, 1'b0, 1'b0);    // R2 pulse width clamped to 2
    runLoad(12, 2, 3, 2, 100, 1, 6, 1'b0, 1'b0);   // R6 one fault, full restart
    runLoad(8, 4, 1, 2, 100, 99, 3, 1'b0, 1'b0);   // R9 every attempt faults
    runLoad(4, 2, 1, 1, 30, 0, 0, 1'b1, 1'b0);     // R7 done never arrives
    repeat (30) @(negedge clk);
    chk("R10", "fail flag held while idle", int'(loadFail), 1);
    chk("R10", "ok flag stays low", int'(loadOk), 0);
    runLoad(6, 2, 2, 0, 100, 1, 2, 1'b0, 1'b0);    // R9 no retries allowed
    runLoad(7, 5, 0, 1, 100, 0, 0, 1'b0, 1'b0);    // R8 zero init clocks
    runLoad(10, 2, 2, 1, 100, 0, 0, 1'b0, 1'b1);   // R2 start while busy ignored
    runLoad(1, 2, 3, 0, 50, 0, 0, 1'b0, 1'b0);     // R5 single byte
    repeat (20) @(negedge clk);
    chk("R10", "ok flag held while idle", int'(loadOk), 1);

    for (int k = 0; k < 8; k++) begin
      int len, nf;
      len = 1 + int'($urandom_range(0, 39));
      nf  = int'($urandom_range(0, 1));
      runLoad(len, int'($urandom_range(0, 6)), int'($urandom_range(0, 20)), 2, 200,
              nf, 1 + int'($urandom_range(0, len - 1)), 1'b0, 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule